// File: doc/BRIEF.md
# E1 Transmit Channel Timing Generator

This block runs on the transmit bit clock of a 2.048 MHz E1 stream. It keeps track of the position of the current bit inside the stream. A frame holds 256 bits, made of 32 timeslots of 8 bits each. A multiframe is a group of 16 frames. From that position the block makes three strobes for the transmit datapath:

- **Channel clock.** It is high only while the last bit of each timeslot goes out. This gives a 256 kHz pulse that a serializer can use to load parallel channel data.
- **Channel-block output.** It takes the value that a per-timeslot mask programs for the current timeslot. It can gate clocks for fractional-rate users or mark timeslots for drop-and-insert.
- **Boundary pulse.** It is produced only when the sync pin is configured as an output.

When the sync pin is configured as an input, a pulse on it realigns the position counters. It aligns them to either a frame start or a multiframe start, as a mode bit selects.

Timeslot size, timeslots per frame and frames per multiframe are parameters. The defaults match E1. All outputs are registered and change only on the rising edge of the bit clock.

Top module: `e1_tx_chan_timing`

## Requirements
- R1: While `rst` is high at a clock edge, `chan_clk`, `chan_blk` and `sync_out` are 0, and the position is set to bit 0, timeslot 0, frame 0. After the first edge with `rst` low, the position is bit 1 of timeslot 0.
- R2: `chan_clk` is 1 exactly during bit position BITS_PER_CH-1 of every timeslot. That is one clock per timeslot, never two in a row.
- R3: `chan_blk` equals `blk_mask[n]` during every bit of timeslot n, where bit n of the mask belongs to timeslot n. The mask is sampled at the edge that starts each bit time, so there is no gap between timeslots.
- R4: Without a sync load, the position moves forward by one bit per clock. Bits go 0 (sent first, the MSB) up to BITS_PER_CH-1 (the LSB). Timeslots go 0 to NUM_CH-1, then frames go 0 to FRAMES_PER_MF-1, and each counter wraps to 0.
- R5: In input mode (`sync_dir_out`=0) with `sync_mf`=0, a 1 on `sync_in` at an edge makes the next bit time bit 0 of timeslot 0. The frame number moves forward by one, wrapping, as at a natural frame end.
- R6: In input mode with `sync_mf`=1, a 1 on `sync_in` at an edge makes the next bit time bit 0 of timeslot 0 of frame 0.
- R7: In output mode (`sync_dir_out`=1) with `sync_mf`=0, `sync_out` is 1 during bit 0 of timeslot 0 of every frame, and 0 at all other times.
- R8: In output mode with `sync_mf`=1, `sync_out` is 1 only during bit 0 of timeslot 0 of frame 0.
- R9: In output mode, `sync_in` has no effect on the position or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Realignment pulse, used in input mode |
| sync_dir_out | input | 1 | 0: sync pin is an input; 1: the block drives `sync_out` |
| sync_mf | input | 1 | 0: frame boundaries; 1: multiframe boundaries |
| blk_mask | input | NUM_CH | Per-timeslot value for `chan_blk`; bit n belongs to timeslot n |
| chan_clk | output | 1 | High during the LSB bit of each timeslot |
| chan_blk | output | 1 | Mask value of the current timeslot |
| sync_out | output | 1 | Frame or multiframe start pulse in output mode |

## Verification
The bench builds the block with 4-bit timeslots, 4 timeslots per frame and 4 frames per multiframe. With these values a frame lasts 16 clocks and a multiframe 64 clocks. Every position, every counter wrap and every multiframe rollover is therefore reached many times in a short run.

At this size the bench can:
- place sync pulses at every few offsets inside a frame;
- walk a single set bit through all mask positions;
- observe the frame number through `sync_out` in multiframe output mode after each realignment.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

  typedef enum logic {
    ALIGN_FRAME = 1'b0,
    ALIGN_MULTI = 1'b1
  } align_e;

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tcg_pos_counter.sv
module tcg_pos_counter
  import tcg_pkg::*;
#(
  parameter int unsigned BITS_PER_CH   = 8,
  parameter int unsigned NUM_CH        = 32,
  parameter int unsigned FRAMES_PER_MF = 16,
  localparam int unsigned BW = idx_w(BITS_PER_CH),
  localparam int unsigned CW = idx_w(NUM_CH),
  localparam int unsigned FW = idx_w(FRAMES_PER_MF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  align_e        align,
  output logic [BW-1:0] bit_q,
  output logic [CW-1:0] ch_q,
  output logic [FW-1:0] fr_q,
  output logic [BW-1:0] bit_d,
  output logic [CW-1:0] ch_d,
  output logic [FW-1:0] fr_d
);

  localparam logic [BW-1:0] BIT_LAST = BW'(BITS_PER_CH - 1);
  localparam logic [CW-1:0] CH_LAST  = CW'(NUM_CH - 1);

  logic bit_wrap;
  logic frame_wrap;

  assign bit_wrap   = (bit_q == BIT_LAST);
  assign frame_wrap = bit_wrap && (ch_q == CH_LAST);

  // bit and timeslot counters
  always_comb begin
    if (load) begin
      bit_d = '0;
      ch_d  = '0;
    end else begin
      bit_d = bit_wrap ? '0 : bit_q + 1'b1;
      if (bit_wrap)
        ch_d = (ch_q == CH_LAST) ? '0 : ch_q + 1'b1;
      else
        ch_d = ch_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= '0;
      ch_q  <= '0;
    end else begin
      bit_q <= bit_d;
      ch_q  <= ch_d;
    end
  end

  // frame counter, absent when the multiframe has a single frame
  generate
    if (FRAMES_PER_MF > 1) begin : g_frame
      localparam logic [FW-1:0] FR_LAST = FW'(FRAMES_PER_MF - 1);
      logic [FW-1:0] fr_inc;
      assign fr_inc = (fr_q == FR_LAST) ? '0 : fr_q + 1'b1;

      always_comb begin
        if (load)
          fr_d = (align == ALIGN_MULTI) ? '0 : fr_inc;
        else if (frame_wrap)
          fr_d = fr_inc;
        else
          fr_d = fr_q;
      end

      always_ff @(posedge clk) begin
        if (rst) fr_q <= '0;
        else     fr_q <= fr_d;
      end

      assert_mf_load_R6: assert property (@(posedge clk) disable iff (rst)
        (load && align == ALIGN_MULTI) |=> (fr_q == '0));
    end else begin : g_no_frame
      assign fr_d = '0;
      always_ff @(posedge clk) fr_q <= '0;
    end
  endgenerate

  assert_load_aligns_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> (bit_q == '0 && ch_q == '0));

  assert_bit_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && !bit_wrap) |=> (bit_q == $past(bit_q) + 1'b1 && ch_q == $past(ch_q)));

endmodule

// File: rtl/tcg_strobe_gen.sv
module tcg_strobe_gen
  import tcg_pkg::*;
#(
  parameter int unsigned BITS_PER_CH   = 8,
  parameter int unsigned NUM_CH        = 32,
  parameter int unsigned FRAMES_PER_MF = 16,
  localparam int unsigned BW = idx_w(BITS_PER_CH),
  localparam int unsigned CW = idx_w(NUM_CH),
  localparam int unsigned FW = idx_w(FRAMES_PER_MF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BW-1:0]     bit_d,
  input  logic [CW-1:0]     ch_d,
  input  logic [FW-1:0]     fr_d,
  input  logic [NUM_CH-1:0] blk_mask,
  input  logic              dir_out,
  input  align_e            align,
  output logic              chan_clk,
  output logic              chan_blk,
  output logic              sync_out
);

  localparam logic [BW-1:0] BIT_LAST = BW'(BITS_PER_CH - 1);

  logic at_frame_start;
  logic at_boundary;

  assign at_frame_start = (bit_d == '0) && (ch_d == '0);
  assign at_boundary    = at_frame_start && ((align == ALIGN_FRAME) || (fr_d == '0));

  // outputs are registered from the next position, so they line up with it
  always_ff @(posedge clk) begin
    if (rst) begin
      chan_clk <= 1'b0;
      chan_blk <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      chan_clk <= (bit_d == BIT_LAST);
      chan_blk <= blk_mask[ch_d];
      sync_out <= dir_out && at_boundary;
    end
  end

  assert_chclk_single_R2: assert property (@(posedge clk) disable iff (rst)
    chan_clk |=> !chan_clk);

endmodule

// File: rtl/e1_tx_chan_timing.sv
module e1_tx_chan_timing
  import tcg_pkg::*;
#(
  parameter int unsigned BITS_PER_CH   = 8,
  parameter int unsigned NUM_CH        = 32,
  parameter int unsigned FRAMES_PER_MF = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_in,
  input  logic              sync_dir_out,
  input  logic              sync_mf,
  input  logic [NUM_CH-1:0] blk_mask,
  output logic              chan_clk,
  output logic              chan_blk,
  output logic              sync_out
);

  localparam int unsigned BW = idx_w(BITS_PER_CH);
  localparam int unsigned CW = idx_w(NUM_CH);
  localparam int unsigned FW = idx_w(FRAMES_PER_MF);
  localparam logic [BW-1:0] BIT_LAST = BW'(BITS_PER_CH - 1);

  logic [BW-1:0] bit_q, bit_d;
  logic [CW-1:0] ch_q, ch_d;
  logic [FW-1:0] fr_q, fr_d;
  logic          load;
  align_e        align;

  assign align = sync_mf ? ALIGN_MULTI : ALIGN_FRAME;
  assign load  = sync_in && !sync_dir_out;

  tcg_pos_counter #(
    .BITS_PER_CH  (BITS_PER_CH),
    .NUM_CH       (NUM_CH),
    .FRAMES_PER_MF(FRAMES_PER_MF)
  ) u_pos (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .align(align),
    .bit_q(bit_q),
    .ch_q (ch_q),
    .fr_q (fr_q),
    .bit_d(bit_d),
    .ch_d (ch_d),
    .fr_d (fr_d)
  );

  tcg_strobe_gen #(
    .BITS_PER_CH  (BITS_PER_CH),
    .NUM_CH       (NUM_CH),
    .FRAMES_PER_MF(FRAMES_PER_MF)
  ) u_strobe (
    .clk     (clk),
    .rst     (rst),
    .bit_d   (bit_d),
    .ch_d    (ch_d),
    .fr_d    (fr_d),
    .blk_mask(blk_mask),
    .dir_out (sync_dir_out),
    .align   (align),
    .chan_clk(chan_clk),
    .chan_blk(chan_blk),
    .sync_out(sync_out)
  );

  assert_chclk_at_lsb_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (chan_clk == (bit_q == BIT_LAST)));

  assert_sync_at_start_R7: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> (bit_q == '0 && ch_q == '0));

  assert_sync_in_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (sync_dir_out && bit_q != BIT_LAST) |=> (bit_q == $past(bit_q) + 1'b1));

endmodule

// File: tb/tb_e1_tx_chan_timing.sv
module tb_e1_tx_chan_timing;
  localparam int B = 4;
  localparam int C = 4;
  localparam int F = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sync_in = 1'b0;
  logic         sync_dir_out = 1'b0;
  logic         sync_mf = 1'b0;
  logic [C-1:0] blk_mask = '0;
  logic         chan_clk, chan_blk, sync_out;

  int    checks = 0;
  int    errors = 0;
  int    m_bit = 0, m_ch = 0, m_fr = 0;
  bit    m_zero = 1'b1;
  logic  e_clk = 1'b0, e_blk = 1'b0, e_sync = 1'b0;
  string phase = "R1";

  e1_tx_chan_timing #(.BITS_PER_CH(B), .NUM_CH(C), .FRAMES_PER_MF(F)) dut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .sync_dir_out(sync_dir_out),
    .sync_mf(sync_mf), .blk_mask(blk_mask),
    .chan_clk(chan_clk), .chan_blk(chan_blk), .sync_out(sync_out)
  );

  always #10 clk = ~clk;

  task automatic chk(logic act, logic exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] %s actual=%0b expected=%0b (bit %0d ch %0d fr %0d)",
               tag, phase, what, act, exp, m_bit, m_ch, m_fr);
    end
  endtask

  // expected position and outputs after one rising edge, from the requirements
  task automatic model_edge();
    if (rst) begin
      m_bit = 0; m_ch = 0; m_fr = 0; m_zero = 1'b1;
      e_clk = 1'b0; e_blk = 1'b0; e_sync = 1'b0;
    end else begin
      m_zero = 1'b0;
      if (sync_in && !sync_dir_out) begin
        m_fr  = sync_mf ? 0 : (m_fr + 1) % F;
        m_bit = 0;
        m_ch  = 0;
      end else if (m_bit == B - 1) begin
        m_bit = 0;
        if (m_ch == C - 1) begin
          m_ch = 0;
          m_fr = (m_fr + 1) % F;
        end else m_ch++;
      end else m_bit++;
      e_clk  = (m_bit == B - 1);
      e_blk  = blk_mask[m_ch];
      e_sync = sync_dir_out && m_bit == 0 && m_ch == 0 && (!sync_mf || m_fr == 0);
    end
  endtask

  task automatic step();
    string stag;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (m_zero) begin
      chk(chan_clk, 1'b0, "R1", "chan_clk in reset");
      chk(chan_blk, 1'b0, "R1", "chan_blk in reset");
      chk(sync_out, 1'b0, "R1", "sync_out in reset");
    end else begin
      stag = sync_dir_out ? (sync_mf ? "R8" : "R7") : phase;
      chk(chan_clk, e_clk, "R2", "chan_clk");
      chk(chan_blk, e_blk, "R3", "chan_blk");
      chk(sync_out, e_sync, stag, "sync_out");
    end
  endtask

  initial begin
    // R1: reset state
    phase = "R1";
    blk_mask = '1;
    sync_dir_out = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    sync_dir_out = 1'b0;

    // R4: free run across two multiframes
    phase = "R4";
    blk_mask = 4'b0101;
    repeat (2 * B * C * F) step();

    // R7: frame pulses
    phase = "R7";
    sync_dir_out = 1'b1;
    sync_mf = 1'b0;
    blk_mask = 4'b1010;
    repeat (B * C * F) step();

    // R8: multiframe pulses
    phase = "R8";
    sync_mf = 1'b1;
    repeat (2 * B * C * F) step();

    // R9: sync_in pulses ignored in output mode, both alignments
    phase = "R9";
    for (int k = 0; k < 160; k++) begin
      sync_in = (k % 11 == 5);
      sync_mf = (k >= 80);
      step();
    end
    sync_in = 1'b0;

    // R5: frame realignment at many offsets, then view frame number
    phase = "R5";
    sync_mf = 1'b0;
    for (int off = 0; off < B * C; off += 3) begin
      sync_dir_out = 1'b0;
      repeat (off + 1) step();
      sync_in = 1'b1;
      step();
      sync_in = 1'b0;
      sync_dir_out = 1'b1;
      sync_mf = 1'b1;
      repeat (B * C * F) step();
      sync_mf = 1'b0;
    end

    // R6: multiframe realignment at many offsets
    phase = "R6";
    for (int off = 0; off < B * C * F; off += 7) begin
      sync_dir_out = 1'b0;
      sync_mf = 1'b1;
      repeat (off + 1) step();
      sync_in = 1'b1;
      step();
      sync_in = 1'b0;
      sync_dir_out = 1'b1;
      repeat (B * C * F) step();
    end

    // R3: walking mask bit, then mask changing every bit time
    phase = "R3";
    sync_dir_out = 1'b0;
    for (int c = 0; c < C; c++) begin
      blk_mask = C'(1) << c;
      repeat (B * C) step();
    end
    for (int k = 0; k < 64; k++) begin
      blk_mask = C'(k * 5 + 3);
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in phase %s actual=running expected=done", phase);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule